// File: doc/BRIEF.md
# Host-Bridge Register Port with Configuration Indirection

This block is the byte-addressable register port of a host-to-PCI bridge. It decodes a 4 KiB offset space and accepts accesses of one, two or four bytes. It checks every access against the width and alignment rules of its target. Legal accesses either act on local state or pass straight through to the downstream side as configuration or I/O cycles. Illegal accesses return an error and change nothing.

A software-visible address register selects the target of indirect cycles. A configuration data window sends a configuration cycle with little-endian byte lanes. An I/O data window sends an I/O cycle with big-endian byte lanes. A few local registers compose or mask their contents instead of storing them as written. These are a two-bit enable register, a fixed-pattern control-transfer address, and a bank of general control registers with a per-register write keep mask and read hardwiring.

A request is presented for one cycle. The downstream cycle is issued combinationally in that same cycle, and downstream read data is expected in that cycle as well. The response (valid, error and read data) is registered and appears one cycle later. Sizes are coded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 is never legal. Read data is right-aligned. On the downstream bus, byte lane k (bits 8k+7:8k) carries the byte at address dn_addr+k.

Top module: `bridge_regport`

## Requirements
- R1: A write to the config address register (offset 0x040) stores all 32 bits, and reads return the stored value unchanged. Every indirect downstream cycle uses that value with bits [1:0] cleared as its base address.
- R2: The config address register accepts only 4-byte accesses at offset 0x040. Any other width there is rejected.
- R3: The config data window (0x044–0x047) issues a configuration cycle (dn_is_io = 0) at base OR offset[1:0]. Lane 0 carries value bits [7:0]. The cycle is issued whether or not bit 31 of the config address is set.
- R4: At the I/O data window (0x048–0x04B), and likewise at the config data window, the legal combinations are: offset 0 with 1, 2 or 4 bytes; offset 2 with 1 or 2 bytes; offsets 1 and 3 with 1 byte only.
- R5: The I/O data window issues an I/O cycle (dn_is_io = 1) at base plus offset[1:0]. Lanes are big-endian: lane 0 carries the most significant byte of a 2- or 4-byte value. Read data is reassembled the same way.
- R6: The fast-back-to-back enable register (0x010) stores only bits [1:0] of a write. Its reset value is 0.
- R7: The control-transfer address register (0x014) resets to 0xFFFA0030. A write stores 0xFFFA0030 OR (write data AND 0x0001E000).
- R8: On reads, bank register 0 (0x800) returns bit 0 as 0, and bank register 2 (0x808) returns bits [2:0] as 0. Bank register 1 (0x804) returns bits 3, 5, 6, 7, 15 and 24 as 0.
- R9: A bank write stores the data ANDed with that register's keep mask. The masks are: register 0 0x0000007F, register 1 0xFFFFFFFF, register 2 0x000000FF, all others 0x0000FFFF.
- R10: An access to an unmapped offset, with an illegal width or alignment, or with size code 3, returns rsp_err = 1. It changes no register and issues no downstream cycle. Local registers accept only 4-byte aligned accesses.
- R11: Every request produces exactly one response, one cycle later. Reads of local registers return their value, and writes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset in the 4 KiB port |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Right-aligned write value |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Right-aligned read value |
| dn_valid | output | 1 | Downstream cycle issued |
| dn_write | output | 1 | Downstream cycle direction |
| dn_is_io | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| dn_addr | output | 32 | Downstream byte address |
| dn_size | output | 2 | Downstream width code |
| dn_wdata | output | 32 | Downstream write data, lane-ordered |
| dn_rdata | input | 32 | Downstream read data, lane-ordered, same cycle |

## Verification
A corrupted stored register only becomes visible when it is read back. The response to that read carries the error one cycle after the request. Each write is therefore followed directly by a read of the same offset. A faulty address register or lane order shows up instead on the downstream pins in the very cycle of the window access. Those pins are sampled while the request is still held. A wrongly accepted illegal access is caught two ways: by rsp_err, and by a later read showing that the target is unchanged.

// File: rtl/bridge_regport_pkg.sv
package bridge_regport_pkg;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_CFGA, TGT_CFGD, TGT_IOD, TGT_FBB, TGT_TOC, TGT_BANK
  } tgt_e;

  localparam int          OFF_W   = 12;
  localparam logic [1:0]  SZ_B1   = 2'd0;
  localparam logic [1:0]  SZ_B2   = 2'd1;
  localparam logic [1:0]  SZ_B4   = 2'd2;

  localparam logic [11:0] OFF_FBB  = 12'h010;
  localparam logic [11:0] OFF_TOC  = 12'h014;
  localparam logic [11:0] OFF_CFGA = 12'h040;
  localparam logic [11:0] OFF_CFGD = 12'h044;
  localparam logic [11:0] OFF_IOD  = 12'h048;
  localparam logic [11:0] OFF_BANK = 12'h800;

  localparam logic [31:0] TOC_BASE = 32'hFFFA0030;
  localparam logic [31:0] TOC_KEEP = 32'h0001E000;
  localparam logic [31:0] FBB_KEEP = 32'h00000003;

  function automatic logic [31:0] bank_keep(input int idx);
    case (idx)
      0:       return 32'h0000007F;
      1:       return 32'hFFFFFFFF;
      2:       return 32'h000000FF;
      default: return 32'h0000FFFF;
    endcase
  endfunction

  function automatic logic [31:0] bank_rd_clear(input int idx);
    case (idx)
      0:       return 32'h00000001;
      1:       return 32'h010080E8;
      2:       return 32'h00000007;
      default: return 32'h00000000;
    endcase
  endfunction

endpackage

// File: rtl/bridge_regport_decode.sv
module bridge_regport_decode
  import bridge_regport_pkg::*;
#(
  parameter int BANK_REGS = 8,
  localparam int BANK_IW  = $clog2(BANK_REGS)
) (
  input  logic [OFF_W-1:0]   offset,
  input  logic [1:0]         size,
  output tgt_e               tgt,
  output logic               legal,
  output logic [BANK_IW-1:0] bank_idx
);
  localparam logic [9:0] BANK_W = OFF_BANK[11:2];
  localparam logic [9:0] BANK_N = 10'(BANK_REGS);

  logic [9:0] word;
  logic [9:0] bank_rel;
  logic       win_ok;
  logic       reg_ok;

  always_comb begin
    word     = offset[11:2];
    bank_rel = word - BANK_W;
    win_ok   = (size == SZ_B1) ||
               (size == SZ_B2 && !offset[0]) ||
               (size == SZ_B4 && offset[1:0] == 2'b00);
    reg_ok   = (size == SZ_B4) && (offset[1:0] == 2'b00);
    bank_idx = bank_rel[BANK_IW-1:0];
    tgt      = TGT_NONE;
    legal    = 1'b0;
    if (word == OFF_CFGA[11:2]) begin
      tgt = TGT_CFGA; legal = reg_ok;
    end else if (word == OFF_CFGD[11:2]) begin
      tgt = TGT_CFGD; legal = win_ok;
    end else if (word == OFF_IOD[11:2]) begin
      tgt = TGT_IOD;  legal = win_ok;
    end else if (word == OFF_FBB[11:2]) begin
      tgt = TGT_FBB;  legal = reg_ok;
    end else if (word == OFF_TOC[11:2]) begin
      tgt = TGT_TOC;  legal = reg_ok;
    end else if (word >= BANK_W && bank_rel < BANK_N) begin
      tgt = TGT_BANK; legal = reg_ok;
    end
  end
endmodule

// File: rtl/bridge_regport_lanes.sv
module bridge_regport_lanes
  import bridge_regport_pkg::*;
(
  input  logic        big_end,
  input  logic [1:0]  size,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  always_comb begin
    case (size)
      SZ_B1:   dout = {24'b0, din[7:0]};
      SZ_B2:   dout = big_end ? {16'b0, din[7:0], din[15:8]} : {16'b0, din[15:0]};
      SZ_B4:   dout = big_end ? {din[7:0], din[15:8], din[23:16], din[31:24]} : din;
      default: dout = 32'b0;
    endcase
  end
endmodule

// File: rtl/bridge_regport_bank.sv
module bridge_regport_bank
  import bridge_regport_pkg::*;
#(
  parameter int BANK_REGS = 8,
  localparam int BANK_IW  = $clog2(BANK_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_IW-1:0] idx,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata
);
  logic [31:0] view [BANK_REGS];

  for (genvar g = 0; g < BANK_REGS; g++) begin : g_reg
    localparam logic [31:0] KEEP  = bank_keep(g);
    localparam logic [31:0] CLEAR = bank_rd_clear(g);
    logic [31:0] q;
    logic [31:0] q_nxt;
    logic        q_en;

    always_comb begin
      q_en  = wr_en && (idx == BANK_IW'(g));
      q_nxt = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (q_en) q <= q_nxt;
    end

    assign view[g] = q & ~CLEAR;
  end

  assign rdata = view[idx];
endmodule

// File: rtl/bridge_regport.sv
module bridge_regport
  import bridge_regport_pkg::*;
#(
  parameter int BANK_REGS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_offset,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        dn_valid,
  output logic        dn_write,
  output logic        dn_is_io,
  output logic [31:0] dn_addr,
  output logic [1:0]  dn_size,
  output logic [31:0] dn_wdata,
  input  logic [31:0] dn_rdata
);
  localparam int BANK_IW = $clog2(BANK_REGS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tgt_e               tgt;
  logic               legal;
  logic [BANK_IW-1:0] bank_idx;

  bridge_regport_decode #(.BANK_REGS(BANK_REGS)) u_dec (
    .offset(req_offset), .size(req_size),
    .tgt(tgt), .legal(legal), .bank_idx(bank_idx)
  );

  logic acc_ok, acc_wr;
  assign acc_ok = req_valid && legal;
  assign acc_wr = acc_ok && req_write;

  // local registers
  logic [31:0] cfga_q, cfga_nxt;
  logic [1:0]  fbb_q,  fbb_nxt;
  logic [31:0] toc_q,  toc_nxt;
  logic        cfga_en, fbb_en, toc_en;

  always_comb begin
    cfga_en  = acc_wr && (tgt == TGT_CFGA);
    fbb_en   = acc_wr && (tgt == TGT_FBB);
    toc_en   = acc_wr && (tgt == TGT_TOC);
    cfga_nxt = req_wdata;
    fbb_nxt  = req_wdata[1:0];
    toc_nxt  = TOC_BASE | (req_wdata & TOC_KEEP);
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cfga_q <= '0;
      fbb_q  <= '0;
      toc_q  <= TOC_BASE;
    end else begin
      if (cfga_en) cfga_q <= cfga_nxt;
      if (fbb_en)  fbb_q  <= fbb_nxt;
      if (toc_en)  toc_q  <= toc_nxt;
    end
  end

  logic [31:0] bank_rdata;
  bridge_regport_bank #(.BANK_REGS(BANK_REGS)) u_bank (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(acc_wr && (tgt == TGT_BANK)),
    .idx(bank_idx), .wdata(req_wdata), .rdata(bank_rdata)
  );

  // downstream cycle
  logic [31:0] dn_rval;
  assign dn_valid = acc_ok && (tgt == TGT_CFGD || tgt == TGT_IOD);
  assign dn_is_io = (tgt == TGT_IOD);
  assign dn_write = req_write;
  assign dn_size  = req_size;
  assign dn_addr  = {cfga_q[31:2], req_offset[1:0]};

  bridge_regport_lanes u_wlanes (
    .big_end(dn_is_io), .size(req_size), .din(req_wdata), .dout(dn_wdata)
  );
  bridge_regport_lanes u_rlanes (
    .big_end(dn_is_io), .size(req_size), .din(dn_rdata), .dout(dn_rval)
  );

  // response
  logic [31:0] rd_mux;
  logic        rsp_valid_nxt, rsp_err_nxt;
  logic [31:0] rsp_rdata_nxt;

  always_comb begin
    case (tgt)
      TGT_CFGA: rd_mux = cfga_q;
      TGT_CFGD: rd_mux = dn_rval;
      TGT_IOD:  rd_mux = dn_rval;
      TGT_FBB:  rd_mux = {30'b0, fbb_q};
      TGT_TOC:  rd_mux = toc_q;
      TGT_BANK: rd_mux = bank_rdata;
      default:  rd_mux = 32'b0;
    endcase
    rsp_valid_nxt = req_valid;
    rsp_err_nxt   = req_valid && !legal;
    rsp_rdata_nxt = (acc_ok && !req_write) ? rd_mux : 32'b0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_nxt;
      rsp_err   <= rsp_err_nxt;
      rsp_rdata <= rsp_rdata_nxt;
    end
  end
endmodule

// File: rtl/bridge_regport_chk.sv
module bridge_regport_chk
  import bridge_regport_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_offset,
  input logic [1:0]  req_size,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        dn_valid,
  input logic        dn_is_io,
  input logic [31:0] dn_addr
);
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_cfga_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_offset == OFF_CFGA && req_size != SZ_B4 |=> rsp_err);
  p_cfg_lowbits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_is_io |-> dn_addr[1:0] == req_offset[1:0]);
  p_io_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_offset[11:2] == OFF_IOD[11:2] && req_offset[0] &&
    req_size != SZ_B1 |=> rsp_err);
  p_io_lowbits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_is_io |-> dn_addr[1:0] == req_offset[1:0]);
  p_fbb_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_offset == OFF_FBB && req_size == SZ_B4
    |=> rsp_rdata[31:2] == 30'b0);
  p_toc_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_offset == OFF_TOC && req_size == SZ_B4
    |=> (rsp_rdata & ~TOC_KEEP) == TOC_BASE);
  p_no_dn_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !rsp_err);
endmodule

bind bridge_regport bridge_regport_chk u_chk (
  .clk(clk), .rst_n(rst_sync), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .dn_valid(dn_valid),
  .dn_is_io(dn_is_io), .dn_addr(dn_addr)
);

// File: tb/bridge_regport_tb_top.sv
module bridge_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0, dn_rdata = '0;
  logic        rsp_valid, rsp_err, dn_valid, dn_write, dn_is_io;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [1:0]  dn_size;

  always #10 clk = ~clk;

  bridge_regport dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_is_io(dn_is_io),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // captured per access
  logic        c_rv, c_err, c_dv, c_dw, c_io;
  logic [31:0] c_rd, c_da, c_dd;
  logic [1:0]  c_ds;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] drd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz;
    req_wdata = wd; dn_rdata = drd;
    #1;
    c_dv = dn_valid; c_dw = dn_write; c_io = dn_is_io;
    c_da = dn_addr; c_dd = dn_wdata; c_ds = dn_size;
    @(negedge clk);
    c_rv = rsp_valid; c_err = rsp_err; c_rd = rsp_rdata;
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        err;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h040, 2'd2, 32'h0,        1'b0, 32'h00000000}, // R1 reset
    '{1'b1, 12'h040, 2'd2, 32'h80001237, 1'b0, 32'h00000000}, // R11 write returns 0
    '{1'b0, 12'h040, 2'd2, 32'h0,        1'b0, 32'h80001237}, // R1 raw readback
    '{1'b1, 12'h040, 2'd0, 32'h0,        1'b1, 32'h00000000}, // R2 byte write
    '{1'b0, 12'h040, 2'd1, 32'h0,        1'b1, 32'h00000000}, // R2 half read
    '{1'b0, 12'h040, 2'd2, 32'h0,        1'b0, 32'h80001237}, // R2 unchanged
    '{1'b0, 12'h014, 2'd2, 32'h0,        1'b0, 32'hFFFA0030}, // R7 reset
    '{1'b1, 12'h014, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h00000000}, // R7
    '{1'b0, 12'h014, 2'd2, 32'h0,        1'b0, 32'hFFFBE030}, // R7 composed
    '{1'b0, 12'h010, 2'd2, 32'h0,        1'b0, 32'h00000000}, // R6 reset
    '{1'b1, 12'h010, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h00000000}, // R6
    '{1'b0, 12'h010, 2'd2, 32'h0,        1'b0, 32'h00000003}, // R6 kept
    '{1'b1, 12'h010, 2'd0, 32'h0,        1'b1, 32'h00000000}, // R10 sub-word
    '{1'b0, 12'h010, 2'd2, 32'h0,        1'b0, 32'h00000003}, // R10 unchanged
    '{1'b1, 12'h800, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h00000000}, // R9
    '{1'b0, 12'h800, 2'd2, 32'h0,        1'b0, 32'h0000007E}, // R8 R9 reg0
    '{1'b1, 12'h804, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h00000000}, // R9
    '{1'b0, 12'h804, 2'd2, 32'h0,        1'b0, 32'hFEFF7F17}, // R8 feature
    '{1'b1, 12'h808, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h00000000}, // R9
    '{1'b0, 12'h808, 2'd2, 32'h0,        1'b0, 32'h000000F8}, // R8 latency
    '{1'b1, 12'h814, 2'd2, 32'h12345678, 1'b0, 32'h00000000}, // R9
    '{1'b0, 12'h814, 2'd2, 32'h0,        1'b0, 32'h00005678}, // R9 reg5
    '{1'b1, 12'h801, 2'd0, 32'hFF,       1'b1, 32'h00000000}, // R10 misaligned
    '{1'b0, 12'h800, 2'd2, 32'h0,        1'b0, 32'h0000007E}, // R10 unchanged
    '{1'b0, 12'h100, 2'd2, 32'h0,        1'b1, 32'h00000000}, // R10 unmapped
    '{1'b1, 12'h820, 2'd2, 32'h1,        1'b1, 32'h00000000}, // R10 past bank
    '{1'b0, 12'h044, 2'd3, 32'h0,        1'b1, 32'h00000000}  // R10 size 3
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R10 reset dn_valid", {31'b0, dn_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].off, VECS[i].sz, VECS[i].wd, 32'h0);
      chk($sformatf("R11 vec%0d rsp_valid", i), {31'b0, c_rv}, 32'h1);
      chk($sformatf("R10 vec%0d err", i), {31'b0, c_err}, {31'b0, VECS[i].err});
      chk($sformatf("R11 vec%0d rdata", i), c_rd, VECS[i].rd);
      if (VECS[i].err)
        chk($sformatf("R10 vec%0d no downstream", i), {31'b0, c_dv}, 32'h0);
    end

    // config address is 0x80001237 from the table: base 0x80001234
    acc(1'b1, 12'h048, 2'd2, 32'hA1B2C3D4, 32'h0);
    chk("R5 io write valid", {29'b0, c_dv, c_io, c_dw}, 32'h7);
    chk("R1 R5 io write addr", c_da, 32'h80001234);
    chk("R5 io write lanes", c_dd, 32'hD4C3B2A1);
    chk("R5 io write size", {30'b0, c_ds}, 32'h2);

    acc(1'b0, 12'h04A, 2'd1, 32'h0, 32'h00002211);
    chk("R5 io read addr", c_da, 32'h80001236);
    chk("R5 io read data", c_rd, 32'h00001122);
    chk("R4 io half at 2 ok", {31'b0, c_err}, 32'h0);

    acc(1'b0, 12'h04B, 2'd0, 32'h0, 32'h000000C7);
    chk("R4 io byte at 3", {c_err, c_dv, 30'b0}, 32'h40000000);
    chk("R5 io byte data", c_rd, 32'h000000C7);

    acc(1'b1, 12'h049, 2'd1, 32'h1234, 32'h0);
    chk("R4 io half at 1 rejected", {30'b0, c_err, c_dv}, 32'h2);
    acc(1'b0, 12'h04A, 2'd2, 32'h0, 32'h0);
    chk("R4 io word at 2 rejected", {30'b0, c_err, c_dv}, 32'h2);

    acc(1'b1, 12'h045, 2'd0, 32'h0000005A, 32'h0);
    chk("R3 cfg write kind", {29'b0, c_dv, c_io, c_dw}, 32'h5);
    chk("R3 cfg write addr", c_da, 32'h80001235);
    chk("R3 cfg write lanes", c_dd, 32'h0000005A);

    acc(1'b0, 12'h044, 2'd2, 32'h0, 32'h44332211);
    chk("R3 cfg read little-endian", c_rd, 32'h44332211);
    acc(1'b1, 12'h046, 2'd1, 32'h0000BEEF, 32'h0);
    chk("R3 cfg half lanes", c_dd, 32'h0000BEEF);
    chk("R3 cfg half addr", c_da, 32'h80001236);

    acc(1'b1, 12'h040, 2'd2, 32'h00000012, 32'h0);
    acc(1'b0, 12'h044, 2'd0, 32'h0, 32'h0);
    chk("R3 no enable check", {31'b0, c_dv}, 32'h1);
    chk("R1 R3 base cleared", c_da, 32'h00000010);

    acc(1'b0, 12'h010, 2'd2, 32'h0, 32'h0);
    chk("R10 local read no downstream", {31'b0, c_dv}, 32'h0);

    // asynchronous reset restores reset values
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    acc(1'b0, 12'h014, 2'd2, 32'h0, 32'h0);
    chk("R7 reset again", c_rd, 32'hFFFA0030);
    acc(1'b0, 12'h804, 2'd2, 32'h0, 32'h0);
    chk("R9 bank reset", c_rd, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule